// File: doc/BRIEF.md
# Video Memory Access Port

This block lets a processor reach a word-organised video memory one byte at a time. The processor selects a register with a 3-bit code and strobes a write or a read. Two registers hold the word address: one takes its low eight bits and one takes its upper bits. Two more registers write the low and high byte lanes of the addressed word. Two further registers return the low and high bytes of that word.

A configuration register controls three things. It sets how far the address advances after an access. It can rotate a small bit field of the address before the address reaches memory, which lets software walk tile data in a different order. It also chooses whether the low-byte or the high-byte access triggers the advance.

Reads do not go to memory directly. They are served from a one-word prefetch buffer, and that buffer is refilled just before each advance.

Top module: `vramAccessPort`

## Requirements
- R1: After reset the configuration, the word address and the prefetch buffer are all zero. Before the first advance, a read of either byte returns 0x00.
- R2: Configuration bits [1:0] set the advance step. 00 adds 1, 01 adds 32, and both 10 and 11 add 128.
- R3: With configuration bits [3:2] = 01, the address presented to memory takes the 3-bit group at bits [7:5] down to bits [2:0] and shifts bits [4:0] up to [7:3]. All higher bits are unchanged. Bits [3:2] = 00 means no remap.
- R4: Remap code 10 performs the same rotation over bits [8:0], moving the group at [8:6]. Remap code 11 performs it over bits [9:0], moving the group at [9:7].
- R5: The remap affects only the memory address. The stored address advances in its plain form. With code 01 and address 0x0003, the access lands on word 0x0018 and the stored address becomes 0x0004.
- R6: Configuration bit 7 chooses the trigger. When it is 0, a low-byte data write or a low-byte read advances the address. When it is 1, the high-byte accesses do so. The other byte never advances it.
- R7: A data write (select 3 for the low lane, 4 for the high lane) updates only its own lane of the addressed word. It does so at once, whether or not it triggers an advance.
- R8: A read (select 5 for the low byte, 6 for the high byte) returns a byte of the prefetch buffer in the same cycle. A triggering read refills the buffer from the current address and then advances, so the first word appears twice.
- R9: Writing the low address byte (select 1) or the high address byte (select 2) reloads the buffer from the new remapped address.
- R10: The address is 15 bits wide and wraps from 0x7FFF to 0x0000.
- R11: The memory holds 2^MemAw words (2048 by default). Address bits above that index alias onto the same words.
- R12: Select 0 writes the configuration register. Selects 7 and above, and reads of selects 0 to 4, have no effect and return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regSel | input | 3 | Register select code |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte, valid in the cycle of regRdEn |

## Verification
The embedded properties check every cycle that the address only moves when a load or an advance occurs, and that each advance is one of the three legal steps. They also check that a remapped address keeps its upper bits and bit count, that a lane write lands in the mapped word, and that an address load fills the buffer from memory. Only the bench scenarios can show the exact remapped locations, the wrap at the top of the address space, the aliasing, and the choice of trigger lane. They also show the duplicate first word that makes a dummy read necessary.

// File: rtl/vramPortPkg.sv
package vramPortPkg;

  typedef enum logic [2:0] {
    SEL_CFG     = 3'd0,
    SEL_ADDR_LO = 3'd1,
    SEL_ADDR_HI = 3'd2,
    SEL_DATA_LO = 3'd3,
    SEL_DATA_HI = 3'd4,
    SEL_READ_LO = 3'd5,
    SEL_READ_HI = 3'd6
  } regSelT;

  typedef struct packed {
    logic       incOnHigh;
    logic [1:0] remapCode;
    logic [1:0] stepCode;
  } cfgT;

  typedef struct packed {
    logic ldAddrLo;
    logic ldAddrHi;
    logic wrLo;
    logic wrHi;
    logic rdLo;
    logic rdHi;
    logic advance;
  } strobeT;

endpackage

// File: rtl/vramPortCtrl.sv
module vramPortCtrl
  import vramPortPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [2:0] regSel,
  input  logic [4:0] cfgIn,   // {incOnHigh, remapCode, stepCode}
  output cfgT        cfg,
  output strobeT     strobes
);

  cfgT    cfgQ;
  regSelT selCode;
  logic   wrHit;
  logic   rdHit;

  assign selCode = regSelT'(regSel);
  assign wrHit   = regWrEn;
  assign rdHit   = regRdEn && !regWrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (wrHit && selCode == SEL_CFG) begin
      cfgQ <= cfgT'(cfgIn);
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.ldAddrLo = wrHit && selCode == SEL_ADDR_LO;
    strobes.ldAddrHi = wrHit && selCode == SEL_ADDR_HI;
    strobes.wrLo     = wrHit && selCode == SEL_DATA_LO;
    strobes.wrHi     = wrHit && selCode == SEL_DATA_HI;
    strobes.rdLo     = rdHit && selCode == SEL_READ_LO;
    strobes.rdHi     = rdHit && selCode == SEL_READ_HI;
    strobes.advance  = cfgQ.incOnHigh ? (strobes.wrHi || strobes.rdHi)
                                      : (strobes.wrLo || strobes.rdLo);
  end

  assign cfg = cfgQ;

  // R6: an advance always comes from an access on the configured lane
  assert_trigger_lane_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |-> (cfgQ.incOnHigh ? (regSel == 3'd4 || regSel == 3'd6)
                                        : (regSel == 3'd3 || regSel == 3'd5)));

endmodule

// File: rtl/vramPortDatapath.sv
module vramPortDatapath
  import vramPortPkg::*;
#(
  parameter int AddrW = 15,
  parameter int MemAw = 11,
  parameter int DataW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               strobes,
  input  cfgT                  cfg,
  input  logic [DataW/2-1:0]   wrByte,
  output logic [DataW/2-1:0]   rdData
);

  localparam int ByteW = DataW / 2;
  localparam int Depth = 1 << MemAw;
  localparam int HiW   = AddrW - ByteW;

  logic [DataW-1:0] mem [Depth];
  logic [AddrW-1:0] addrQ;
  logic [AddrW-1:0] loadAddr;
  logic [AddrW-1:0] memAddr;
  logic [AddrW-1:0] loadMemAddr;
  logic [AddrW-1:0] stepVal;
  logic [DataW-1:0] rdBufQ;
  logic [DataW-1:0] curWord;
  logic [DataW-1:0] mergedWord;
  logic             loadAny;

  function automatic logic [AddrW-1:0] remapFn(input logic [AddrW-1:0] a,
                                               input logic [1:0] code);
    logic [AddrW-1:0] r;
    r = a;
    case (code)
      2'd1:    r[7:0] = {a[4:0], a[7:5]};
      2'd2:    r[8:0] = {a[5:0], a[8:6]};
      2'd3:    r[9:0] = {a[6:0], a[9:7]};
      default: r = a;
    endcase
    return r;
  endfunction

  assign loadAny = strobes.ldAddrLo || strobes.ldAddrHi;

  always_comb begin
    loadAddr = addrQ;
    if (strobes.ldAddrLo) loadAddr[ByteW-1:0] = wrByte;
    if (strobes.ldAddrHi) loadAddr[AddrW-1:ByteW] = wrByte[HiW-1:0];
  end

  assign memAddr     = remapFn(addrQ, cfg.remapCode);
  assign loadMemAddr = remapFn(loadAddr, cfg.remapCode);
  assign curWord     = mem[memAddr[MemAw-1:0]];

  always_comb begin
    mergedWord = curWord;
    if (strobes.wrLo) mergedWord[ByteW-1:0]     = wrByte;
    if (strobes.wrHi) mergedWord[DataW-1:ByteW] = wrByte;
  end

  always_comb begin
    case (cfg.stepCode)
      2'd0:    stepVal = AddrW'(1);
      2'd1:    stepVal = AddrW'(32);
      default: stepVal = AddrW'(128);
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobes.wrLo) mem[memAddr[MemAw-1:0]][ByteW-1:0]     <= wrByte;
    if (strobes.wrHi) mem[memAddr[MemAw-1:0]][DataW-1:ByteW] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      rdBufQ <= '0;
    end else if (loadAny) begin
      addrQ  <= loadAddr;
      rdBufQ <= mem[loadMemAddr[MemAw-1:0]];
    end else if (strobes.advance) begin
      rdBufQ <= mergedWord;
      addrQ  <= addrQ + stepVal;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdLo) rdData = rdBufQ[ByteW-1:0];
    if (strobes.rdHi) rdData = rdBufQ[DataW-1:ByteW];
  end

  // R5: the stored address is still when nothing loads or advances it
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(loadAny || strobes.advance) |=> $stable(addrQ));

  // R2: every advance is one of the legal steps, modulo the address width
  assert_step_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !loadAny) |=>
      (AddrW'(addrQ - $past(addrQ)) == AddrW'(1)  ||
       AddrW'(addrQ - $past(addrQ)) == AddrW'(32) ||
       AddrW'(addrQ - $past(addrQ)) == AddrW'(128)));

  // R3: the remap is a rotation, so it keeps the upper bits and the bit count
  assert_remap_rotate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memAddr[AddrW-1:10] == addrQ[AddrW-1:10]) &&
    ($countones(memAddr) == $countones(addrQ)));

  // R4: the same holds for the address about to be loaded
  assert_load_rotate_R4: assert property (@(posedge clk) disable iff (!rstN)
    loadAny |-> ($countones(loadMemAddr) == $countones(loadAddr)));

  // R7: a low-lane write lands in the mapped word
  assert_lane_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrLo |=> mem[$past(memAddr[MemAw-1:0])][ByteW-1:0] == $past(wrByte));

  // R9: an address load fills the buffer from the newly mapped word
  assert_load_fill_R9: assert property (@(posedge clk) disable iff (!rstN)
    loadAny |=> rdBufQ == mem[$past(loadMemAddr[MemAw-1:0])]);

endmodule

// File: rtl/vramAccessPort.sv
module vramAccessPort
  import vramPortPkg::*;
#(
  parameter int AddrW = 15,
  parameter int MemAw = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [2:0] regSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData
);

  cfgT    cfg;
  strobeT strobes;

  vramPortCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regSel  (regSel),
    .cfgIn   ({wrData[7], wrData[3:0]}),
    .cfg     (cfg),
    .strobes (strobes)
  );

  vramPortDatapath #(
    .AddrW (AddrW),
    .MemAw (MemAw),
    .DataW (16)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .cfg     (cfg),
    .wrByte  (wrData),
    .rdData  (rdData)
  );

endmodule

// File: tb/sim_vramAccessPort.sv
module sim_vramAccessPort;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [2:0] regSel = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  vramAccessPort u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regSel(regSel), .wrData(wrData), .rdData(rdData)
  );

  typedef struct packed {
    logic       isRead;
    logic [2:0] sel;
    logic [7:0] data;
    logic       chk;
    logic [7:0] exp;
  } vecT;

  localparam int NVec = 22;
  // sel: 0 cfg, 1 addr lo, 2 addr hi, 3 data lo, 4 data hi, 5 read lo, 6 read hi
  localparam vecT VEC [NVec] = '{
    '{1'b0, 3'd0, 8'h80, 1'b0, 8'h00},  // trigger on high lane, step 1
    '{1'b0, 3'd1, 8'h10, 1'b0, 8'h00},
    '{1'b0, 3'd2, 8'h00, 1'b0, 8'h00},
    '{1'b0, 3'd3, 8'h34, 1'b0, 8'h00},
    '{1'b0, 3'd4, 8'h12, 1'b0, 8'h00},  // word 0x10 = 0x1234
    '{1'b0, 3'd3, 8'h78, 1'b0, 8'h00},
    '{1'b0, 3'd4, 8'h56, 1'b0, 8'h00},  // word 0x11 = 0x5678
    '{1'b0, 3'd1, 8'h10, 1'b0, 8'h00},  // R9 reload from 0x10
    '{1'b1, 3'd5, 8'h00, 1'b1, 8'h34},
    '{1'b1, 3'd6, 8'h00, 1'b1, 8'h12},  // R8 triggers: refill from 0x10
    '{1'b1, 3'd5, 8'h00, 1'b1, 8'h34},  // R8 duplicate first word
    '{1'b1, 3'd6, 8'h00, 1'b1, 8'h12},
    '{1'b1, 3'd5, 8'h00, 1'b1, 8'h78},
    '{1'b0, 3'd0, 8'h01, 1'b0, 8'h00},  // R6 low trigger, step 32
    '{1'b0, 3'd1, 8'h00, 1'b0, 8'h00},
    '{1'b0, 3'd2, 8'h01, 1'b0, 8'h00},  // address 0x100
    '{1'b0, 3'd3, 8'hAA, 1'b0, 8'h00},  // advances to 0x120
    '{1'b0, 3'd4, 8'hBB, 1'b0, 8'h00},  // no advance
    '{1'b0, 3'd3, 8'hCC, 1'b0, 8'h00},  // word 0x120 = 0xBBCC
    '{1'b0, 3'd1, 8'h20, 1'b0, 8'h00},  // reload 0x120
    '{1'b1, 3'd6, 8'h00, 1'b1, 8'hBB},
    '{1'b1, 3'd5, 8'h00, 1'b1, 8'hCC}
  };

  task automatic doOp(input bit isRead, input logic [2:0] sel,
                      input logic [7:0] d, output logic [7:0] got);
    @(negedge clk);
    regWrEn = !isRead;
    regRdEn = isRead;
    regSel  = sel;
    wrData  = d;
    #2;
    got = rdData;
    @(posedge clk);
    #1;
    regWrEn = 1'b0;
    regRdEn = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    logic [7:0] unused;
    doOp(1'b0, sel, d, unused);
  endtask

  task automatic rdChk(input logic [2:0] sel, input logic [7:0] exp, input string req);
    logic [7:0] got;
    doOp(1'b1, sel, 8'h00, got);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: sel %0d read 0x%02h expected 0x%02h", req, sel, got, exp);
    end
  endtask

  task automatic setAddr(input logic [14:0] a);
    wr(3'd1, a[7:0]);
    wr(3'd2, {1'b0, a[14:8]});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state, high read first so nothing advances
    rdChk(3'd6, 8'h00, "R1");
    rdChk(3'd5, 8'h00, "R1");

    // table walk, R8 / R9 / R6 / R7
    for (int i = 0; i < NVec; i++) begin
      logic [7:0] got;
      doOp(VEC[i].isRead, VEC[i].sel, VEC[i].data, got);
      if (VEC[i].chk) begin
        checks++;
        if (got !== VEC[i].exp) begin
          fails++;
          $display("FAIL R8 table row %0d: read 0x%02h expected 0x%02h", i, got, VEC[i].exp);
        end
      end
    end

    // R7: a low-only write keeps the high lane
    wr(3'd0, 8'h80);
    setAddr(15'h0010);
    wr(3'd3, 8'h99);
    setAddr(15'h0010);
    rdChk(3'd5, 8'h99, "R7");
    rdChk(3'd6, 8'h12, "R7");

    // R2: step codes 10 and 11 both add 128
    wr(3'd0, 8'h82);
    setAddr(15'h0200);
    wr(3'd3, 8'h02); wr(3'd4, 8'h01);
    wr(3'd3, 8'h04); wr(3'd4, 8'h03);   // lands at 0x280
    setAddr(15'h0280);
    rdChk(3'd6, 8'h03, "R2");
    wr(3'd0, 8'h83);
    setAddr(15'h0300);
    wr(3'd3, 8'h06); wr(3'd4, 8'h05);
    wr(3'd3, 8'h08); wr(3'd4, 8'h07);   // lands at 0x380
    setAddr(15'h0380);
    rdChk(3'd6, 8'h07, "R2");
    rdChk(3'd5, 8'h08, "R2");

    // R3 / R5: remap 01 at 0x0003 hits 0x0018, stored address becomes 0x0004
    wr(3'd0, 8'h84);
    setAddr(15'h0003);
    wr(3'd3, 8'hEF); wr(3'd4, 8'hBE);
    wr(3'd0, 8'h80);
    wr(3'd3, 8'h11); wr(3'd4, 8'h22);   // plain address 0x0004
    setAddr(15'h0018);
    rdChk(3'd5, 8'hEF, "R3");
    rdChk(3'd6, 8'hBE, "R3");
    setAddr(15'h0004);
    rdChk(3'd5, 8'h11, "R5");
    rdChk(3'd6, 8'h22, "R5");

    // R4: remap 10 maps 0x1C5 to 0x02F, remap 11 maps 0x383 to 0x01F
    wr(3'd0, 8'h88);
    setAddr(15'h01C5);
    wr(3'd3, 8'h5A); wr(3'd4, 8'hA5);
    wr(3'd0, 8'h8C);
    setAddr(15'h0383);
    wr(3'd3, 8'h3C); wr(3'd4, 8'hC3);
    wr(3'd0, 8'h80);
    setAddr(15'h002F);
    rdChk(3'd5, 8'h5A, "R4");
    rdChk(3'd6, 8'hA5, "R4");
    setAddr(15'h001F);
    rdChk(3'd5, 8'h3C, "R4");
    rdChk(3'd6, 8'hC3, "R4");

    // R10 / R11: wrap at 0x7FFF, alias onto 0x7FF
    setAddr(15'h7FFF);
    wr(3'd3, 8'h33); wr(3'd4, 8'h44);
    wr(3'd3, 8'h55); wr(3'd4, 8'h66);   // should land at 0x0000
    setAddr(15'h0000);
    rdChk(3'd5, 8'h55, "R10");
    setAddr(15'h07FF);
    rdChk(3'd5, 8'h33, "R11");

    // R12: reading a write-only select returns zero
    rdChk(3'd3, 8'h00, "R12");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule